// File: doc/BRIEF.md
# Event Timer Global Block: Main Counter and Shared Registers

This block is the shared half of a multi-channel high-precision event timer. It holds the 64-bit free-running main counter, a read-only capability word pair and a small global configuration register with a run bit and a legacy-routing bit. A 32-bit register port gives access to all of them. The counter advances once for every clock in which an external tick strobe is high and the run bit is set. When the run bit is cleared, the counter stops and keeps its value. While it is stopped, software may load it one half at a time.

The block drives the count value and the two configuration flags to the per-channel comparator logic. Each channel also gets a one-cycle arm strobe when the run bit turns on and a one-cycle disarm strobe when it turns off. A channel is not armed if it reports that its comparator holds all ones. Interrupt routing and the comparators themselves belong to other blocks.

Top module: `evt_global_core`

## Requirements
- R1: After reset, the counter is 0, the run flag and the legacy flag are 0, the write-error flag is 0, and no arm or disarm strobe is active.
- R2: A read at offset 0x000 returns 0x8086A001 OR (N-1) shifted left by 8, where N is the channel-count parameter clamped to the range 3 to 32. A read at offset 0x004 returns the tick period in femtoseconds.
- R3: The configuration word is at offset 0x010. Bit 0 is the run flag and bit 1 is the legacy flag. All other bits of a write are ignored and read back as 0. Writes to offset 0x014 change nothing, and reads of 0x014 return 0.
- R4: On each rising clock edge where the run flag (as held before that edge) is 1 and tick_en is 1, the counter increases by exactly one, with carry from the low half into the high half.
- R5: While the run flag is 0, the counter holds its value even if tick_en is high. Setting the run flag again makes counting resume from the held value.
- R6: Offset 0x0F0 reads the low 32 bits of the counter and offset 0x0F4 reads the high 32 bits. Read data appears on bus_rdata in the cycle after the request and is 0 in every other cycle.
- R7: While the run flag is 0, a write to 0x0F0 or 0x0F4 replaces that half of the counter.
- R8: A counter write while the run flag is 1 leaves the counter unchanged and sets wr_err. Once set, wr_err stays at 1 until reset.
- R9: A configuration write that takes the run flag from 0 to 1 produces a one-cycle arm strobe, in the same cycle in which run_en rises. The strobe goes to every channel whose ch_cmp_all_ones input was 0 during the write cycle.
- R10: A write that takes the run flag from 1 to 0 produces a one-cycle disarm strobe on all channels. A write that leaves the run flag unchanged produces no strobe.
- R11: An access whose bus_size is not 4 (bytes), or whose offset is not word-aligned, is ignored: it writes nothing and reads 0. Reads of unmapped offsets return 0, and writes to them change nothing.
- R12: When the write that clears the run flag falls on a clock with tick_en high, that tick is still counted. When the write that sets the run flag falls on a clock with tick_en high, that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter tick strobe |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte offset |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| ch_cmp_all_ones | input | NCH | Per-channel flag: the channel's comparator holds all ones |
| cnt_value | output | 64 | Current main counter |
| run_en | output | 1 | Global run flag |
| legacy_en | output | 1 | Legacy routing flag |
| ch_arm | output | NCH | One-cycle arm strobe per channel |
| ch_disarm | output | NCH | One-cycle disarm strobe per channel |
| wr_err | output | 1 | Sticky flag for a counter write while running |

## Verification
Two things can happen on the same clock edge: a tick increment and a configuration write that changes the run flag. The bench provokes both orders by raising tick_en in the same cycle as the run-flag write. It first sends a write that turns the run flag on and, on the next edge, a write that turns it off, with the tick strobe held high across both edges. Reading the frozen count afterwards must show exactly one more tick than before. This shows that the tick on the enabling edge was dropped and the tick on the disabling edge was kept.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 64;
    localparam int MIN_CH   = 3;
    localparam int MAX_CH   = 32;
    localparam int ACC_BYTES = 4;

    localparam logic [DATA_W-1:0] CAP_BASE   = 32'h8086_A001;
    localparam int                CH_FLD_LSB = 8;

    localparam logic [ADDR_W-1:0] OFS_CAP_LO = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CAP_HI = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_CFG_LO = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_CFG_HI = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 12'h0F0;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 12'h0F4;

    localparam int CFG_RUN_BIT = 0;
    localparam int CFG_LEG_BIT = 1;

    typedef enum logic [2:0] {
        RS_NONE, RS_CAP_LO, RS_CAP_HI, RS_CFG_LO, RS_CFG_HI, RS_CNT_LO, RS_CNT_HI
    } reg_sel_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        reg_sel_e         sel;
        logic [DATA_W-1:0] data;
    } bus_op_t;

    typedef struct packed {
        logic legacy;
        logic run;
    } gcfg_t;

    function automatic int clamp_ch(input int n);
        if (n < MIN_CH) return MIN_CH;
        if (n > MAX_CH) return MAX_CH;
        return n;
    endfunction

    function automatic logic [DATA_W-1:0] cap_low_word(input int nch);
        logic [DATA_W-1:0] fld;
        fld = DATA_W'(nch - 1) << CH_FLD_LSB;
        return CAP_BASE | fld;
    endfunction

endpackage

// File: rtl/evt_reg_decode.sv
module evt_reg_decode
    import evt_pkg::*;
(
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output bus_op_t           op
);
    logic     legal;
    reg_sel_e which;

    always_comb begin
        legal = sel && (size == 3'(ACC_BYTES)) && (addr[1:0] == 2'b00);
        unique case (addr)
            OFS_CAP_LO: which = RS_CAP_LO;
            OFS_CAP_HI: which = RS_CAP_HI;
            OFS_CFG_LO: which = RS_CFG_LO;
            OFS_CFG_HI: which = RS_CFG_HI;
            OFS_CNT_LO: which = RS_CNT_LO;
            OFS_CNT_HI: which = RS_CNT_HI;
            default:    which = RS_NONE;
        endcase
        op.rd   = legal && !we;
        op.wr   = legal && we;
        op.sel  = legal ? which : RS_NONE;
        op.data = wdata;
    end

    always_comb begin
        if (op.rd || op.wr) begin
            a_legal_size_r11: assert (size == 3'(ACC_BYTES))
                else $error("decoded access with illegal size");
        end
    end
endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter
    import evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick_en,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic              err
);
    localparam int HALF = CNT_W / 2;

    logic any_wr;
    assign any_wr = wr_lo || wr_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            err <= 1'b0;
        end else if (run) begin
            if (tick_en) cnt <= cnt + CNT_W'(1);
            if (any_wr)  err <= 1'b1;
        end else begin
            if (wr_lo) cnt[HALF-1:0]     <= wdata;
            if (wr_hi) cnt[CNT_W-1:HALF] <= wdata;
        end
    end

    p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
        run && tick_en |=> cnt == $past(cnt) + CNT_W'(1));

    p_halt_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !run && !any_wr |=> $stable(cnt));

    p_run_write_dropped_r8: assert property (@(posedge clk) disable iff (rst)
        run && any_wr && !tick_en |=> $stable(cnt) && err);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
endmodule

// File: rtl/evt_gcfg.sv
module evt_gcfg
    import evt_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_lo,
    input  logic           wr_hi,
    input  logic [1:0]     wbits,
    input  logic [NCH-1:0] cmp_all_ones,
    output gcfg_t          cfg,
    output logic [NCH-1:0] arm,
    output logic [NCH-1:0] disarm
);
    gcfg_t cfg_next;
    logic  rising, falling;

    always_comb begin
        cfg_next = cfg;
        if (wr_lo) begin
            cfg_next.run    = wbits[CFG_RUN_BIT];
            cfg_next.legacy = wbits[CFG_LEG_BIT];
        end
        rising  = cfg_next.run && !cfg.run;
        falling = !cfg_next.run && cfg.run;
    end

    always_ff @(posedge clk) begin
        if (rst) cfg <= '0;
        else     cfg <= cfg_next;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                arm[i]    <= 1'b0;
                disarm[i] <= 1'b0;
            end else begin
                arm[i]    <= rising && !cmp_all_ones[i];
                disarm[i] <= falling;
            end
        end
    end

    p_arm_only_on_rise_r9: assert property (@(posedge clk) disable iff (rst)
        |arm |-> $rose(cfg.run));

    p_rise_arms_eligible_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg.run) |-> arm == ~$past(cmp_all_ones));

    p_disarm_all_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
        |disarm |-> (&disarm) && $fell(cfg.run));

    p_no_both_strobes_r10: assert property (@(posedge clk) disable iff (rst)
        !(|arm && |disarm));

    p_cfg_hi_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        wr_hi && !wr_lo |=> $stable(cfg));
endmodule

// File: rtl/evt_global_core.sv
module evt_global_core
    import evt_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int TICK_FS = 10_000_000,
    localparam int NCH    = clamp_ch(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [11:0]       bus_addr,
    input  logic [2:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCH-1:0]    ch_cmp_all_ones,
    output logic [63:0]       cnt_value,
    output logic              run_en,
    output logic              legacy_en,
    output logic [NCH-1:0]    ch_arm,
    output logic [NCH-1:0]    ch_disarm,
    output logic              wr_err
);
    localparam logic [DATA_W-1:0] CAP_LO = cap_low_word(NCH);
    localparam logic [DATA_W-1:0] CAP_HI = DATA_W'(TICK_FS);
    localparam int                HALF   = CNT_W / 2;

    bus_op_t          op;
    gcfg_t            cfg;
    logic [CNT_W-1:0] cnt;
    logic [DATA_W-1:0] rd_mux;

    evt_reg_decode u_dec (
        .sel   (bus_sel),
        .we    (bus_we),
        .addr  (bus_addr),
        .size  (bus_size),
        .wdata (bus_wdata),
        .op    (op)
    );

    evt_gcfg #(.NCH(NCH)) u_cfg (
        .clk          (clk),
        .rst          (rst),
        .wr_lo        (op.wr && op.sel == RS_CFG_LO),
        .wr_hi        (op.wr && op.sel == RS_CFG_HI),
        .wbits        (op.data[1:0]),
        .cmp_all_ones (ch_cmp_all_ones),
        .cfg          (cfg),
        .arm          (ch_arm),
        .disarm       (ch_disarm)
    );

    evt_main_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (cfg.run),
        .tick_en (tick_en),
        .wr_lo   (op.wr && op.sel == RS_CNT_LO),
        .wr_hi   (op.wr && op.sel == RS_CNT_HI),
        .wdata   (op.data),
        .cnt     (cnt),
        .err     (wr_err)
    );

    always_comb begin
        unique case (op.sel)
            RS_CAP_LO: rd_mux = CAP_LO;
            RS_CAP_HI: rd_mux = CAP_HI;
            RS_CFG_LO: rd_mux = {30'b0, cfg.legacy, cfg.run};
            RS_CNT_LO: rd_mux = cnt[HALF-1:0];
            RS_CNT_HI: rd_mux = cnt[CNT_W-1:HALF];
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        bus_rdata <= '0;
        else if (op.rd) bus_rdata <= rd_mux;
        else            bus_rdata <= '0;
    end

    assign cnt_value = cnt;
    assign run_en    = cfg.run;
    assign legacy_en = cfg.legacy;

    p_idle_rdata_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> bus_rdata == '0);

    p_bad_size_reads_zero_r11: assert property (@(posedge clk) disable iff (rst)
        bus_sel && bus_size != 3'd4 |=> bus_rdata == '0);
endmodule

// File: tb/sim_evt_global_core.sv
module sim_evt_global_core;
    localparam int NUM_CH  = 4;
    localparam int TICK_FS = 10_000_000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [2:0]  bus_size = 3'd4;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  ch_cmp_all_ones = '0;
    logic [63:0] cnt_value;
    logic        run_en, legacy_en, wr_err;
    logic [3:0]  ch_arm, ch_disarm;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5ns clk = ~clk;

    evt_global_core #(.NUM_CH(NUM_CH), .TICK_FS(TICK_FS)) u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_cmp_all_ones(ch_cmp_all_ones), .cnt_value(cnt_value),
        .run_en(run_en), .legacy_en(legacy_en),
        .ch_arm(ch_arm), .ch_disarm(ch_disarm), .wr_err(wr_err)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input logic [2:0] sz = 3'd4);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_size = 3'd4;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, input logic [2:0] sz = 3'd4);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0; bus_size = 3'd4;
    endtask

    task automatic t_reset;
        check(cnt_value == 64'd0, "R1 counter", cnt_value, 0);
        check(!run_en && !legacy_en, "R1 flags", {run_en, legacy_en}, 0);
        check(!wr_err, "R1 wr_err", wr_err, 0);
        check(ch_arm == 0 && ch_disarm == 0, "R1 strobes", {ch_arm, ch_disarm}, 0);
    endtask

    task automatic t_capability;
        logic [31:0] d;
        bus_rd(12'h000, d);
        check(d == 32'h8086_A301, "R2 cap low", d, 32'h8086_A301);
        bus_rd(12'h004, d);
        check(d == 32'(TICK_FS), "R2 cap high", d, TICK_FS);
    endtask

    task automatic t_config;
        logic [31:0] d;
        bus_wr(12'h010, 32'hFFFF_FFFE);
        bus_rd(12'h010, d);
        check(d == 32'h2, "R3 cfg masked write", d, 2);
        check(legacy_en && !run_en, "R3 legacy flag", {legacy_en, run_en}, 2'b10);
        bus_wr(12'h014, 32'hFFFF_FFFF);
        bus_rd(12'h010, d);
        check(d == 32'h2, "R3 upper write ignored", d, 2);
        bus_rd(12'h014, d);
        check(d == 32'h0, "R3 upper reads zero", d, 0);
        bus_wr(12'h010, 32'h0);
        check(!legacy_en, "R3 legacy cleared", legacy_en, 0);
    endtask

    task automatic t_load_halted;
        logic [31:0] d;
        bus_wr(12'h0F0, 32'hFFFF_FFFE);
        bus_wr(12'h0F4, 32'h0);
        bus_rd(12'h0F0, d);
        check(d == 32'hFFFF_FFFE, "R7 low half load", d, 32'hFFFF_FFFE);
        bus_rd(12'h0F4, d);
        check(d == 32'h0, "R7 high half load", d, 0);
        @(negedge clk); tick_en = 1'b1;
        repeat (4) @(negedge clk);
        tick_en = 1'b0;
        check(cnt_value == 64'hFFFF_FFFE, "R5 halted hold", cnt_value, 64'hFFFF_FFFE);
    endtask

    task automatic t_count_and_strobes;
        logic [31:0] d;
        ch_cmp_all_ones = 4'b0100;
        bus_wr(12'h010, 32'h1);
        check(run_en, "R9 run rises", run_en, 1);
        check(ch_arm == 4'b1011, "R9 arm eligible", ch_arm, 4'b1011);
        @(negedge clk);
        check(ch_arm == 4'b0000, "R9 arm one cycle", ch_arm, 0);
        bus_wr(12'h010, 32'h1);
        check(ch_arm == 0 && ch_disarm == 0, "R10 no strobe on same value", {ch_arm, ch_disarm}, 0);
        tick_en = 1'b1;
        repeat (5) @(negedge clk);
        tick_en = 1'b0;
        check(cnt_value == 64'h1_0000_0003, "R4 count with carry", cnt_value, 64'h1_0000_0003);
        bus_wr(12'h010, 32'h0);
        check(ch_disarm == 4'b1111, "R10 disarm all", ch_disarm, 4'b1111);
        @(negedge clk);
        check(ch_disarm == 4'b0000, "R10 disarm one cycle", ch_disarm, 0);
        bus_rd(12'h0F0, d);
        check(d == 32'h3, "R6 read low", d, 3);
        bus_rd(12'h0F4, d);
        check(d == 32'h1, "R6 read high", d, 1);
        ch_cmp_all_ones = 4'b0000;
    endtask

    task automatic t_resume;
        bus_wr(12'h010, 32'h1);
        tick_en = 1'b1;
        repeat (2) @(negedge clk);
        tick_en = 1'b0;
        bus_wr(12'h010, 32'h0);
        check(cnt_value == 64'h1_0000_0005, "R5 resume from held", cnt_value, 64'h1_0000_0005);
    endtask

    task automatic t_run_write_error;
        logic [31:0] d;
        bus_wr(12'h010, 32'h1);
        bus_wr(12'h0F0, 32'h1234);
        check(wr_err, "R8 error set", wr_err, 1);
        bus_wr(12'h010, 32'h0);
        bus_rd(12'h0F0, d);
        check(d == 32'h5, "R8 write dropped", d, 5);
        check(wr_err, "R8 error sticky", wr_err, 1);
    endtask

    task automatic t_illegal_access;
        logic [31:0] d;
        bus_wr(12'h010, 32'h1, 3'd2);
        check(!run_en, "R11 short cfg write ignored", run_en, 0);
        bus_rd(12'h000, d, 3'd2);
        check(d == 32'h0, "R11 short read zero", d, 0);
        bus_rd(12'h020, d);
        check(d == 32'h0, "R11 unmapped read zero", d, 0);
        bus_wr(12'h0F0, 32'hAAAA_AAAA, 3'd1);
        check(cnt_value == 64'h1_0000_0005, "R11 byte counter write ignored", cnt_value, 64'h1_0000_0005);
        bus_wr(12'h0F1, 32'hAAAA_AAAA);
        check(cnt_value == 64'h1_0000_0005, "R11 misaligned write ignored", cnt_value, 64'h1_0000_0005);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        tick_en = 1'b1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h010; bus_wdata = 32'h1; bus_size = 3'd4;
        @(negedge clk);
        check(cnt_value == 64'h1_0000_0005, "R12 enabling edge not counted", cnt_value, 64'h1_0000_0005);
        bus_wdata = 32'h0;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; tick_en = 1'b0;
        check(!run_en, "R12 run cleared", run_en, 0);
        check(cnt_value == 64'h1_0000_0006, "R12 disabling edge counted", cnt_value, 64'h1_0000_0006);
    endtask

    initial begin
        #(200000 * 5ns);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_capability();
        t_config();
        t_load_halted();
        t_count_and_strobes();
        t_resume();
        t_run_write_error();
        t_illegal_access();
        t_same_cycle();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule